// File: doc/BRIEF.md
# Staged Three-Channel PWM Register Bank

This block holds the settings for three pulse-width-modulated outputs and generates the outputs from them. Settings arrive as single byte writes: a write strobe, an 8-bit register address and an 8-bit data byte. A free-running 8-bit period counter advances on a clock-enable input. Each output is high while the counter is below that channel's active duty value.

Duty values and per-channel on/off bits are never written straight into the comparators. They land in staging registers. A write of any value to the commit address arms a transfer. The transfer copies every staged value into the active set in one step, at the next counter wrap, so no output period is cut short.

A control register carries a software shutdown bit and a global channel enable. Clearing either forces every output low, and the stored settings are kept. An active-low hardware shutdown input does the same from outside. A mode register bit is stored and presented on a port for the breathing sequencer that sits next to this block. A write of any value to the soft-reset address restores every default, as the synchronous reset does.

Top module: `led_pwm_bank`

## Requirements
- R1: After reset all outputs are low and `mode_auto` is 0. The defaults are: control bit 0 = 1, control bit 5 = 0, all duties 00h, channel enables 111b, no commit pending, counter 0.
- R2: A write to addresses 04h, 05h or 06h stores the duty of channel 1, 2 or 3 in a staging register. The output does not change until a commit completes.
- R3: A write of any value to 07h arms a commit. At the next wrap (counter = 255 while `pwm_tick` = 1) every staged duty and enable is copied to the active set together. Active values change at no other time except reset.
- R4: The output register of channel n is set to 1 at an edge exactly when the counter is below the active duty. The output is therefore high for duty/256 of each period: 00h is never high, and FFh is high 255 ticks out of 256.
- R5: Address 1Dh bits [2:0] are staged on/off bits for channels 3..1 (bit 0 = channel 1). A 0 in an active bit holds that output low.
- R6: Address 00h bit 0 = 0 (software shutdown) forces all outputs low from the next edge. Duties, enables and mode are retained, and setting the bit back to 1 resumes the same outputs.
- R7: Address 00h bit 5 is the global enable. When it is 0, all outputs are low.
- R8: `hw_sd_n` = 0 forces all outputs low at the following edge, with settings retained.
- R9: A write of any value to 2Fh restores all defaults of R1, including the counter and the staging registers.
- R10: Address 02h bit 5 is the mode select (0 direct, 1 automatic). It appears on `mode_auto` one edge after the write.
- R11: Writes to any other address change no state and no output.
- R12: The period counter advances only on edges where `pwm_tick` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Write data |
| pwm_tick | input | 1 | Period counter clock enable |
| hw_sd_n | input | 1 | Hardware shutdown, active low |
| pwm_out | output | 3 | PWM outputs, bit 0 = channel 1 |
| mode_auto | output | 1 | Stored mode select bit |

## Verification
A wrong active duty or enable shows on the outputs within one PWM period, as a pulse of the wrong width. A commit that lands off the wrap shows as a truncated or stretched period, on the very next edges after the transfer. A stalled or skipping counter shifts every later edge of all three outputs. A lost shutdown or enable bit shows on the edge after the write. The bench's cycle model compares every output on every clock, so any of these is reported in the cycle it first appears.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
  localparam logic [7:0] ADDR_CTRL   = 8'h00;
  localparam logic [7:0] ADDR_MODE   = 8'h02;
  localparam logic [7:0] ADDR_DUTY0  = 8'h04;
  localparam logic [7:0] ADDR_COMMIT = 8'h07;
  localparam logic [7:0] ADDR_CHEN   = 8'h1D;
  localparam logic [7:0] ADDR_SRST   = 8'h2F;
  localparam int CTRL_SSD_BIT = 0;
  localparam int CTRL_GEN_BIT = 5;
  localparam int MODE_SEL_BIT = 5;
endpackage

// File: rtl/led_pwm_counter.sv
module led_pwm_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          tick,
  output logic [DW-1:0] cnt,
  output logic          wrap
);
  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  assign wrap = tick && (cnt == {DW{1'b1}});
endmodule

// File: rtl/led_pwm_regs.sv
module led_pwm_regs
  import led_pwm_pkg::*;
#(
  parameter int CH = 3,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             wrap,
  output logic             soft_rst,
  output logic [CH*DW-1:0] act_duty,
  output logic [CH-1:0]    act_en,
  output logic             ssd_q,
  output logic             gen_q,
  output logic             mode_q
);
  logic [CH*DW-1:0] stg_duty;
  logic [CH-1:0]    stg_en;
  logic             pend_q;

  assign soft_rst = wr_en && (wr_addr == ADDR_SRST);

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      stg_duty <= '0;
      act_duty <= '0;
      stg_en   <= '1;
      act_en   <= '1;
      pend_q   <= 1'b0;
      ssd_q    <= 1'b1;
      gen_q    <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      if (pend_q && wrap) begin
        act_duty <= stg_duty;
        act_en   <= stg_en;
        pend_q   <= 1'b0;
      end
      if (wr_en) begin
        if (wr_addr == ADDR_CTRL) begin
          ssd_q <= wr_data[CTRL_SSD_BIT];
          gen_q <= wr_data[CTRL_GEN_BIT];
        end
        if (wr_addr == ADDR_MODE)   mode_q <= wr_data[MODE_SEL_BIT];
        if (wr_addr == ADDR_COMMIT) pend_q <= 1'b1;
        if (wr_addr == ADDR_CHEN)   stg_en <= wr_data[CH-1:0];
        for (int i = 0; i < CH; i++) begin
          if (wr_addr == ADDR_DUTY0 + 8'(i))
            stg_duty[i*DW +: DW] <= wr_data[DW-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/led_pwm_chan.sv
module led_pwm_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          en,
  input  logic [DW-1:0] duty,
  input  logic [DW-1:0] cnt,
  output logic          pwm
);
  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= run && en && (cnt < duty);
  end
endmodule

// File: rtl/led_pwm_bank.sv
module led_pwm_bank #(
  parameter int CH = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [7:0]    wr_addr,
  input  logic [7:0]    wr_data,
  input  logic          pwm_tick,
  input  logic          hw_sd_n,
  output logic [CH-1:0] pwm_out,
  output logic          mode_auto
);
  logic [DW-1:0]    cnt_q;
  logic             wrap;
  logic             soft_rst;
  logic [CH*DW-1:0] act_duty;
  logic [CH-1:0]    act_en;
  logic             ssd_q, gen_q;
  logic             run;

  led_pwm_regs #(.CH(CH), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .wrap(wrap), .soft_rst(soft_rst), .act_duty(act_duty), .act_en(act_en),
    .ssd_q(ssd_q), .gen_q(gen_q), .mode_q(mode_auto)
  );

  led_pwm_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .clr(soft_rst), .tick(pwm_tick), .cnt(cnt_q), .wrap(wrap)
  );

  assign run = hw_sd_n && ssd_q && gen_q;

  for (genvar g = 0; g < CH; g++) begin : g_ch
    led_pwm_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst(rst), .run(run), .en(act_en[g]),
      .duty(act_duty[g*DW +: DW]), .cnt(cnt_q), .pwm(pwm_out[g])
    );
  end
endmodule

// File: rtl/led_pwm_bank_chk.sv
module led_pwm_bank_chk
  import led_pwm_pkg::*;
#(
  parameter int CH = 3,
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic             wr_mode_bit,
  input logic             pwm_tick,
  input logic             hw_sd_n,
  input logic [CH-1:0]    pwm_out,
  input logic             mode_auto,
  input logic [DW-1:0]    cnt,
  input logic [CH*DW-1:0] act_duty,
  input logic [CH-1:0]    act_en,
  input logic             ssd,
  input logic             gen
);
  logic srst_w, listed;
  assign srst_w = wr_en && (wr_addr == ADDR_SRST);
  assign listed = (wr_addr == ADDR_CTRL) || (wr_addr == ADDR_MODE) ||
                  (wr_addr == ADDR_COMMIT) || (wr_addr == ADDR_CHEN) ||
                  (wr_addr == ADDR_SRST) ||
                  (wr_addr >= ADDR_DUTY0 && wr_addr < ADDR_DUTY0 + 8'(CH));

  a_r8_hw_off: assert property (@(posedge clk) disable iff (rst)
    !hw_sd_n |=> (pwm_out == '0));
  a_r6_sw_off: assert property (@(posedge clk) disable iff (rst)
    !ssd |=> (pwm_out == '0));
  a_r7_gen_off: assert property (@(posedge clk) disable iff (rst)
    !gen |=> (pwm_out == '0));
  a_r12_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (!pwm_tick && !srst_w) |=> $stable(cnt));
  a_r3_commit_at_wrap: assert property (@(posedge clk) disable iff (rst)
    (!(pwm_tick && cnt == {DW{1'b1}}) && !srst_w) |=> ($stable(act_duty) && $stable(act_en)));
  a_r10_mode_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_MODE) |=> (mode_auto == $past(wr_mode_bit)));
  a_r11_unlisted_mode: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !listed) |=> $stable(mode_auto));

  for (genvar g = 0; g < CH; g++) begin : g_zero
    a_r4_zero_duty: assert property (@(posedge clk) disable iff (rst)
      (act_duty[g*DW +: DW] == '0) |=> !pwm_out[g]);
  end
endmodule

bind led_pwm_bank led_pwm_bank_chk #(.CH(CH), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_mode_bit(wr_data[led_pwm_pkg::MODE_SEL_BIT]), .pwm_tick(pwm_tick),
  .hw_sd_n(hw_sd_n), .pwm_out(pwm_out), .mode_auto(mode_auto), .cnt(cnt_q),
  .act_duty(act_duty), .act_en(act_en), .ssd(ssd_q), .gen(gen_q)
);

// File: tb/led_pwm_bank_tb.sv
module led_pwm_bank_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       we = 1'b0;
  logic [7:0] addr = '0;
  logic [7:0] data = '0;
  logic       tick = 1'b0;
  logic       hwn = 1'b1;
  logic [2:0] pwm_out;
  logic       mode_auto;

  always #4 clk = ~clk;

  led_pwm_bank u_dut (
    .clk(clk), .rst(rst), .wr_en(we), .wr_addr(addr), .wr_data(data),
    .pwm_tick(tick), .hw_sd_n(hwn), .pwm_out(pwm_out), .mode_auto(mode_auto)
  );

  int    vecs = 0;
  int    errs = 0;
  int    cycles = 0;
  string req = "R1";

  // behavioural reference
  int       m_cnt;
  int       m_sduty[3];
  int       m_aduty[3];
  bit [2:0] m_sen, m_aen, m_out, n_out;
  bit       m_ssd, m_gen, m_mode, m_pend, m_run, m_wrap;

  task automatic m_defaults();
    m_cnt = 0; m_sen = 3'b111; m_aen = 3'b111;
    m_ssd = 1; m_gen = 0; m_mode = 0; m_pend = 0;
    for (int i = 0; i < 3; i++) begin m_sduty[i] = 0; m_aduty[i] = 0; end
  endtask

  initial begin m_defaults(); m_out = '0; end

  always @(posedge clk) begin
    cycles++;
    m_wrap = tick && (m_cnt == 255);
    m_run  = hwn && m_ssd && m_gen;
    for (int i = 0; i < 3; i++)
      n_out[i] = !rst && m_run && m_aen[i] && (m_cnt < m_aduty[i]);
    if (rst || (we && addr == 8'h2F)) m_defaults();
    else begin
      if (m_pend && m_wrap) begin
        for (int i = 0; i < 3; i++) m_aduty[i] = m_sduty[i];
        m_aen = m_sen; m_pend = 0;
      end
      if (we) begin
        case (addr)
          8'h00: begin m_ssd = data[0]; m_gen = data[5]; end
          8'h02: m_mode = data[5];
          8'h04, 8'h05, 8'h06: m_sduty[addr - 8'h04] = data;
          8'h07: m_pend = 1;
          8'h1D: m_sen = data[2:0];
          default: ;
        endcase
      end
      if (tick) m_cnt = (m_cnt + 1) % 256;
    end
    m_out = n_out;
  end

  task automatic cyc(input bit w, input logic [7:0] a, input logic [7:0] d, input bit t);
    @(negedge clk);
    vecs++;
    if (pwm_out !== m_out || mode_auto !== m_mode) begin
      errs++;
      $display("FAIL %s pwm_out=%b mode=%b expected pwm_out=%b mode=%b",
               req, pwm_out, mode_auto, m_out, m_mode);
    end
    we = w; addr = a; data = d; tick = t;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(1, a, d, 1);
  endtask

  task automatic run_n(input int n, input bit every_other);
    for (int k = 0; k < n; k++) cyc(0, 8'h00, 8'h00, every_other ? bit'(k % 2) : 1'b1);
  endtask

  initial begin
    while (cycles < 200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    req = "R1"; // reset state
    run_n(4, 0);
    rst = 1'b0;
    run_n(300, 0);
    req = "R7"; // global enable on, duties still zero
    wr(8'h00, 8'h21);
    run_n(50, 0);
    req = "R2"; // staged only, no commit
    wr(8'h04, 8'h04); wr(8'h05, 8'h80); wr(8'h06, 8'hFF);
    run_n(600, 0);
    req = "R3"; // commit lands at wrap
    wr(8'h07, 8'h5A);
    run_n(700, 0);
    req = "R4"; // duty 00 and FF
    wr(8'h04, 8'h00); wr(8'h05, 8'h01); wr(8'h07, 8'h00);
    run_n(600, 0);
    req = "R12"; // tick only every other cycle
    run_n(1100, 1);
    req = "R5"; // enables 101b
    wr(8'h1D, 8'h05); wr(8'h07, 8'h00);
    run_n(600, 0);
    req = "R6"; // software shutdown keeps settings
    wr(8'h00, 8'h20);
    run_n(300, 0);
    wr(8'h00, 8'h21);
    run_n(300, 0);
    req = "R7";
    wr(8'h00, 8'h01);
    run_n(300, 0);
    wr(8'h00, 8'h21);
    req = "R8";
    hwn = 1'b0;
    run_n(300, 0);
    hwn = 1'b1;
    run_n(300, 0);
    req = "R10";
    wr(8'h02, 8'h20);
    run_n(20, 0);
    req = "R11"; // unlisted addresses
    wr(8'h03, 8'hFF); wr(8'h08, 8'h00); wr(8'h1E, 8'h00); wr(8'h30, 8'h00); wr(8'h01, 8'h00);
    wr(8'h07, 8'h00);
    run_n(600, 0);
    req = "R9"; // soft reset restores defaults
    wr(8'h2F, 8'h00);
    run_n(300, 0);
    wr(8'h00, 8'h21); wr(8'h06, 8'h10); wr(8'h07, 8'h00);
    run_n(600, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule